// File: doc/BRIEF.md
# Trace loop offload controller

This block runs a hot looping trace on behalf of a host core. The host first loads bundle configuration words into an internal configuration RAM. It then pulses `start` with a trace index and streams the loop's live-in registers into the engine. The engine steps through the trace's bundle slots, one bundle per step. Arithmetic results go into a working register file. Memory writes are parked in a small store buffer. When an iteration finishes with every guard satisfied, the buffered stores drain to the memory port in program order, and the working registers are checkpointed.

Every iteration is speculative. The loop ends only when a guard bundle fails, or when the store buffer has no room for another store. At that point the partial iteration is thrown away: its buffered stores are dropped and the registers roll back to the last checkpoint. All internal registers are then streamed back to the host, and a one-cycle `done` reports the slot that caused the exit and how many iterations committed. The host re-executes the squashed iteration itself.

Top module: `trace_offload_ctrl`

## Requirements
- R1: After reset, `done`, `mem_valid` and `xout_valid` are low.
- R2: A `start` clears every internal register to zero. Each `xin_valid` beat then writes `xin_data` to register `xin_addr`, and the beat with `xin_last` high ends the live-in phase.
- R3: Trace `t` slot `s` lives at configuration address `t*SLOTS+s`. A configuration word is {op[20:18], last[17], rd[16:14], ra[13:11], rb[10:8], imm[7:0]}. The op codes are: 0 no-op; 1 rd=ra+rb; 2 rd=ra+imm (zero-extended); 3 store with address ra and data rb; 4 guard that passes when ra<rb (unsigned); 5 guard that passes when ra!=rb.
- R4: An iteration ends after the bundle with `last` set, or after slot SLOTS-1. The next iteration restarts at slot 0 with the updated registers.
- R5: Stores reach the memory port only after an iteration completes with no guard failure. They leave in program order.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R7: A failing guard squashes the iteration in progress. None of its stores reach memory, and the registers return to the values committed by the previous iteration. No store is issued during the live-out phase.
- R8: A store issued while the buffer already holds SB_DEPTH entries is handled as a side exit at that slot.
- R9: After an exit, registers 0 to NREGS-1 are presented on `xout_*` in ascending order, one per cycle.
- R10: `done` is a one-cycle pulse in the cycle right after the last live-out beat. It carries `done_slot` (the exiting slot) and `done_iters` (the number of committed iterations).
- R11: When a guard fails in a bundle that also has `last` set, the squash takes priority: that iteration neither commits nor drains.
- R12: A `start` that arrives while a trace is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration RAM write enable |
| cfg_addr | input | 6 | Configuration write address (trace, slot) |
| cfg_wdata | input | 21 | Configuration word |
| start | input | 1 | Begin a trace offload |
| start_trace | input | 2 | Trace index to run |
| xin_valid | input | 1 | Live-in beat valid |
| xin_last | input | 1 | Final live-in beat |
| xin_addr | input | 3 | Live-in register number |
| xin_data | input | 16 | Live-in value |
| xout_valid | output | 1 | Live-out beat valid |
| xout_addr | output | 3 | Live-out register number |
| xout_data | output | 16 | Live-out value |
| mem_valid | output | 1 | Store request valid |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | 16 | Store address |
| mem_data | output | 16 | Store data |
| done | output | 1 | Offload finished pulse |
| done_slot | output | 4 | Slot whose bundle caused the exit |
| done_iters | output | 16 | Committed iteration count |

## Verification
Two events can fall in the same cycle: the end of an iteration and a guard failure, when the final bundle of a trace is both the guard and the bundle that carries `last`. The accumulate trace is built exactly this way. It runs for N passes, and on pass N the guard fails in that combined bundle. The run is judged by the stores seen at the port: there must be exactly N-1, with addresses and sums from a bench-side model. The committed count and the rolled-back live-outs must also match that model. A second run repeats the same trace while `mem_ready` stalls periodically, so the drain of each committed iteration overlaps back-pressure.

// File: rtl/tlo_pkg.sv
package tlo_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDI  = 3'd2,
    OP_STORE = 3'd3,
    OP_GLTU  = 3'd4,
    OP_GNE   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIVEIN,
    ST_FETCH,
    ST_EXEC,
    ST_DRAIN,
    ST_SQUASH,
    ST_LIVEOUT,
    ST_DONE
  } state_e;

endpackage

// File: rtl/tlo_cfg_ram.sv
// Simple dual-port configuration store: synchronous write, registered read.
module tlo_cfg_ram #(
  parameter int AW = 6,
  parameter int W  = 21
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tlo_regfile.sv
// Working registers plus a shadow copy taken at every iteration commit.
module tlo_regfile #(
  parameter int DW    = 16,
  parameter int NREGS = 8,
  parameter int RAW   = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           ld_en,
  input  logic [RAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           commit,
  input  logic           restore,
  input  logic [RAW-1:0] ra_addr,
  input  logic [RAW-1:0] rb_addr,
  output logic [DW-1:0]  ra_data,
  output logic [DW-1:0]  rb_data
);
  logic [DW-1:0] work_v [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [RAW-1:0] IDX = RAW'(g);
    logic [DW-1:0] w_q;
    logic [DW-1:0] c_q;

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        w_q <= '0;
        c_q <= '0;
      end else if (restore) begin
        w_q <= c_q;
      end else begin
        if (ld_en && ld_addr == IDX) begin
          w_q <= ld_data;
          c_q <= ld_data;
        end
        if (wr_en && wr_addr == IDX) w_q <= wr_data;
        if (commit) c_q <= w_q;
      end
    end

    assign work_v[g] = w_q;
  end

  assign ra_data = work_v[ra_addr];
  assign rb_data = work_v[rb_addr];

endmodule

// File: rtl/tlo_store_buf.sv
// Linear store buffer: filled during an iteration, drained or cleared at its end.
module tlo_store_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [DW-1:0] head_addr,
  output logic [DW-1:0] head_data
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNTW-1:0] FULLV = CNTW'(DEPTH);

  logic [2*DW-1:0] ent [DEPTH];
  logic [CNTW-1:0] wr_cnt;
  logic [CNTW-1:0] rd_ptr;

  assign full  = (wr_cnt == FULLV);
  assign empty = (rd_ptr == wr_cnt);
  assign {head_addr, head_data} = ent[rd_ptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) ent[wr_cnt[IW-1:0]] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) wr_cnt <= wr_cnt + 1'b1;
      if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/tlo_exec.sv
// Bundle decode and evaluation; purely combinational.
module tlo_exec #(
  parameter int DW   = 16,
  parameter int RAW  = 3,
  parameter int IMMW = 8,
  parameter int CW   = 4 + 3 * RAW + IMMW
) (
  input  logic [CW-1:0]  word,
  input  logic [DW-1:0]  a_val,
  input  logic [DW-1:0]  b_val,
  output logic [RAW-1:0] ra,
  output logic [RAW-1:0] rb,
  output logic [RAW-1:0] rd,
  output logic           last,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic           push,
  output logic           guard_fail
);
  import tlo_pkg::*;

  op_e           op;
  logic [DW-1:0] imm_ext;

  assign op      = op_e'(word[CW-1 -: 3]);
  assign last    = word[CW-4];
  assign rd      = word[CW-5 -: RAW];
  assign ra      = word[CW-5-RAW -: RAW];
  assign rb      = word[CW-5-2*RAW -: RAW];
  assign imm_ext = DW'(word[IMMW-1:0]);

  always_comb begin
    wr_en      = 1'b0;
    wr_data    = a_val + b_val;
    push       = 1'b0;
    guard_fail = 1'b0;
    case (op)
      OP_ADD:   wr_en = 1'b1;
      OP_ADDI: begin
        wr_en   = 1'b1;
        wr_data = a_val + imm_ext;
      end
      OP_STORE: push = 1'b1;
      OP_GLTU:  guard_fail = !(a_val < b_val);
      OP_GNE:   guard_fail = (a_val == b_val);
      default: ;
    endcase
  end

endmodule

// File: rtl/trace_offload_ctrl.sv
module trace_offload_ctrl #(
  parameter int DW       = 16,
  parameter int NREGS    = 8,
  parameter int TRACES   = 4,
  parameter int SLOTS    = 16,
  parameter int SB_DEPTH = 4,
  parameter int IMMW     = 8,
  parameter int ITW      = 16,
  localparam int RAW = $clog2(NREGS),
  localparam int TIW = $clog2(TRACES),
  localparam int SW  = $clog2(SLOTS),
  localparam int CAW = TIW + SW,
  localparam int CW  = 4 + 3 * RAW + IMMW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           start,
  input  logic [TIW-1:0] start_trace,
  input  logic           xin_valid,
  input  logic           xin_last,
  input  logic [RAW-1:0] xin_addr,
  input  logic [DW-1:0]  xin_data,
  output logic           xout_valid,
  output logic [RAW-1:0] xout_addr,
  output logic [DW-1:0]  xout_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic           done,
  output logic [SW-1:0]  done_slot,
  output logic [ITW-1:0] done_iters
);
  import tlo_pkg::*;

  localparam logic [SW-1:0]  SLOT_MAX = SW'(SLOTS - 1);
  localparam logic [RAW-1:0] LO_MAX   = RAW'(NREGS - 1);

  state_e         st;
  logic [TIW-1:0] trace_q;
  logic [SW-1:0]  slot_q;
  logic [SW-1:0]  exit_q;
  logic [RAW-1:0] lo_idx;
  logic [ITW-1:0] iters_q;

  logic [CW-1:0]  cfg_rdata;
  logic [RAW-1:0] ex_ra, ex_rb, ex_rd, rf_ra_addr;
  logic           ex_last, ex_wr_en, ex_push, ex_gfail;
  logic [DW-1:0]  ex_wr_data, rf_a, rf_b;
  logic           sb_full, sb_empty;

  logic in_exec, side_exit, ends_iter, commit, squash, drain_go;

  assign in_exec    = (st == ST_EXEC);
  assign side_exit  = in_exec && (ex_gfail || (ex_push && sb_full));
  assign ends_iter  = ex_last || (slot_q == SLOT_MAX);
  assign commit     = (st == ST_DRAIN) && sb_empty;
  assign squash     = (st == ST_SQUASH);
  assign drain_go   = (st == ST_DRAIN) && !sb_empty;
  assign rf_ra_addr = (st == ST_LIVEOUT) ? lo_idx : ex_ra;
  assign mem_valid  = drain_go;

  tlo_cfg_ram #(.AW(CAW), .W(CW)) u_cfg (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr ({trace_q, slot_q}),
    .rdata (cfg_rdata)
  );

  tlo_exec #(.DW(DW), .RAW(RAW), .IMMW(IMMW), .CW(CW)) u_exec (
    .word       (cfg_rdata),
    .a_val      (rf_a),
    .b_val      (rf_b),
    .ra         (ex_ra),
    .rb         (ex_rb),
    .rd         (ex_rd),
    .last       (ex_last),
    .wr_en      (ex_wr_en),
    .wr_data    (ex_wr_data),
    .push       (ex_push),
    .guard_fail (ex_gfail)
  );

  tlo_regfile #(.DW(DW), .NREGS(NREGS), .RAW(RAW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .clear   ((st == ST_IDLE) && start),
    .ld_en   ((st == ST_LIVEIN) && xin_valid),
    .ld_addr (xin_addr),
    .ld_data (xin_data),
    .wr_en   (in_exec && !side_exit && ex_wr_en),
    .wr_addr (ex_rd),
    .wr_data (ex_wr_data),
    .commit  (commit),
    .restore (squash),
    .ra_addr (rf_ra_addr),
    .rb_addr (ex_rb),
    .ra_data (rf_a),
    .rb_data (rf_b)
  );

  tlo_store_buf #(.DW(DW), .DEPTH(SB_DEPTH)) u_sb (
    .clk       (clk),
    .rst       (rst),
    .clear     (squash || commit),
    .push      (in_exec && !side_exit && ex_push),
    .push_addr (rf_a),
    .push_data (rf_b),
    .pop       (drain_go && mem_ready),
    .full      (sb_full),
    .empty     (sb_empty),
    .head_addr (mem_addr),
    .head_data (mem_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      trace_q    <= '0;
      slot_q     <= '0;
      exit_q     <= '0;
      lo_idx     <= '0;
      iters_q    <= '0;
      xout_valid <= 1'b0;
      xout_addr  <= '0;
      xout_data  <= '0;
      done       <= 1'b0;
      done_slot  <= '0;
      done_iters <= '0;
    end else begin
      done       <= 1'b0;
      xout_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          trace_q <= start_trace;
          iters_q <= '0;
          slot_q  <= '0;
          st      <= ST_LIVEIN;
        end
        ST_LIVEIN: if (xin_valid && xin_last) begin
          slot_q <= '0;
          st     <= ST_FETCH;
        end
        ST_FETCH: st <= ST_EXEC;
        ST_EXEC: begin
          if (side_exit) begin
            exit_q <= slot_q;
            st     <= ST_SQUASH;
          end else if (ends_iter) begin
            st <= ST_DRAIN;
          end else begin
            slot_q <= slot_q + 1'b1;
            st     <= ST_FETCH;
          end
        end
        ST_DRAIN: if (sb_empty) begin
          iters_q <= iters_q + 1'b1;
          slot_q  <= '0;
          st      <= ST_FETCH;
        end
        ST_SQUASH: begin
          lo_idx <= '0;
          st     <= ST_LIVEOUT;
        end
        ST_LIVEOUT: begin
          xout_valid <= 1'b1;
          xout_addr  <= lo_idx;
          xout_data  <= rf_a;
          if (lo_idx == LO_MAX) st <= ST_DONE;
          else lo_idx <= lo_idx + 1'b1;
        end
        ST_DONE: begin
          done       <= 1'b1;
          done_slot  <= exit_q;
          done_iters <= iters_q;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlo_checker.sv
module tlo_checker #(
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [DW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_data,
  input logic           xout_valid,
  input logic [RAW-1:0] xout_addr,
  input logic           done
);

  assert_store_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_no_store_in_liveout_R7: assert property (@(posedge clk) disable iff (rst)
    xout_valid |-> !mem_valid);

  assert_liveout_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(xout_valid) |-> (xout_addr == '0));

  assert_liveout_step_R9: assert property (@(posedge clk) disable iff (rst)
    (xout_valid && $past(xout_valid)) |-> (xout_addr == RAW'($past(xout_addr) + 1'b1)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_liveout_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(xout_valid) && !xout_valid));

endmodule

bind trace_offload_ctrl tlo_checker #(.DW(DW), .RAW(RAW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .xout_valid (xout_valid),
  .xout_addr  (xout_addr),
  .done       (done)
);

// File: tb/sim_trace_offload_ctrl.sv
module sim_trace_offload_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [20:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [1:0]  start_trace = '0;
  logic        xin_valid = 1'b0;
  logic        xin_last = 1'b0;
  logic [2:0]  xin_addr = '0;
  logic [15:0] xin_data = '0;
  logic        xout_valid;
  logic [2:0]  xout_addr;
  logic [15:0] xout_data;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic [15:0] mem_data;
  logic        done;
  logic [3:0]  done_slot;
  logic [15:0] done_iters;

  trace_offload_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .start_trace(start_trace), .xin_valid(xin_valid), .xin_last(xin_last),
    .xin_addr(xin_addr), .xin_data(xin_data), .xout_valid(xout_valid), .xout_addr(xout_addr),
    .xout_data(xout_data), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .done_slot(done_slot), .done_iters(done_iters)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit stall = 1'b0;

  logic [15:0] st_addr [32];
  logic [15:0] st_data [32];
  int          st_n;
  logic [15:0] lo_val [8];
  int          lo_n;
  int          lo_bad;
  int          done_cnt;
  logic [3:0]  d_slot;
  logic [15:0] d_iters;
  logic [15:0] lin [8];
  int          lin_n;

  // Port monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    cyc++;
    mem_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    if (mem_valid && mem_ready) begin
      if (st_n < 32) begin
        st_addr[st_n] = mem_addr;
        st_data[st_n] = mem_data;
      end
      st_n++;
    end
    if (xout_valid) begin
      if (int'(xout_addr) != lo_n) lo_bad++;
      lo_val[xout_addr] = xout_data;
      lo_n++;
    end
    if (done) begin
      done_cnt++;
      d_slot  = done_slot;
      d_iters = done_iters;
    end
    if (cyc == WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [20:0] cw(input int op, input int last, input int rd,
                                     input int ra, input int rb, input int imm);
    return {op[2:0], last[0], rd[2:0], ra[2:0], rb[2:0], imm[7:0]};
  endfunction

  task automatic cfg_put(input int tr, input int slot, input logic [20:0] w);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 6'(tr * 16 + slot);
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs a trace with live-ins lin[0..lin_n-1]; optionally pokes start mid-run (R12).
  task automatic run_trace(input int tr, input bit poke);
    st_n = 0; lo_n = 0; lo_bad = 0; done_cnt = 0;
    for (int k = 0; k < 8; k++) lo_val[k] = 16'hdead;
    @(negedge clk);
    start = 1'b1;
    start_trace = 2'(tr);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < lin_n; k++) begin
      xin_valid = 1'b1;
      xin_addr  = 3'(k);
      xin_data  = lin[k];
      xin_last  = (k == lin_n - 1);
      @(negedge clk);
    end
    xin_valid = 1'b0;
    xin_last  = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      start_trace = 2'd2;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == 0; t++) begin
      @(negedge clk);
      #1;
    end
    repeat (4) @(negedge clk);
    chk("R10", "done pulse count", 32'(done_cnt), 32'd1);
    chk("R9", "live-out order errors", 32'(lo_bad), 32'd0);
    chk("R9", "live-out beats", 32'(lo_n), 32'd8);
  endtask

  // Accumulate loop: N passes, guard and last flag share the final bundle (R11).
  task automatic test_accumulate(input bit with_stall);
    int n = 5;
    logic [15:0] addr = 16'h0100, acc = 0, i = 0;
    int exp_st = 0;
    stall = with_stall;
    lin[0] = 16'h0100; lin[1] = 0; lin[2] = 0; lin[3] = 16'(n); lin[4] = 3; lin_n = 5;
    run_trace(0, 1'b0);
    for (int k = 1; k <= n; k++) begin
      logic [15:0] ni = i + 1, na = acc + 3, nadr = addr + 1;
      if (!(ni < 16'(n))) break;
      if (exp_st < 32 && exp_st < st_n) begin
        chk("R5", "store address", 32'(st_addr[exp_st]), 32'(nadr));
        chk("R5", "store data", 32'(st_data[exp_st]), 32'(na));
      end
      i = ni; acc = na; addr = nadr; exp_st++;
    end
    chk("R11", "committed stores (N-1)", 32'(st_n), 32'(exp_st));
    chk("R11", "done_iters", 32'(d_iters), 32'(n - 1));
    chk("R3", "done_slot", 32'(d_slot), 32'd4);
    chk("R7", "live-out r0", 32'(lo_val[0]), 32'(addr));
    chk("R7", "live-out r1", 32'(lo_val[1]), 32'(acc));
    chk("R7", "live-out r2", 32'(lo_val[2]), 32'(i));
    chk("R2", "live-out r3", 32'(lo_val[3]), 32'(n));
    chk("R2", "live-out r4", 32'(lo_val[4]), 32'd3);
    if (with_stall) chk("R6", "stores under back-pressure", 32'(st_n), 32'd4);
    stall = 1'b0;
  endtask

  // Guard in the middle of an iteration; a stray start is ignored.
  task automatic test_mid_guard;
    lin[0] = 16'h0200; lin[1] = 0; lin[2] = 0; lin[3] = 2; lin_n = 4;
    run_trace(1, 1'b1);
    chk("R7", "stores (only first iteration)", 32'(st_n), 32'd1);
    chk("R5", "store addr", 32'(st_addr[0]), 32'h0200);
    chk("R5", "store data", 32'(st_data[0]), 32'd1);
    chk("R7", "rolled back r1", 32'(lo_val[1]), 32'd1);
    chk("R7", "rolled back r0", 32'(lo_val[0]), 32'h0201);
    chk("R12", "done_slot unaffected by stray start", 32'(d_slot), 32'd2);
    chk("R12", "done_iters", 32'(d_iters), 32'd1);
  endtask

  // Fifth store into a four-entry buffer forces an exit.
  task automatic test_overflow;
    lin[0] = 16'h0300; lin[1] = 7; lin_n = 2;
    run_trace(2, 1'b0);
    chk("R8", "no stores reach memory", 32'(st_n), 32'd0);
    chk("R8", "done_slot at overflowing store", 32'(d_slot), 32'd4);
    chk("R8", "done_iters", 32'(d_iters), 32'd0);
    chk("R2", "r0 live-in", 32'(lo_val[0]), 32'h0300);
    chk("R2", "r1 live-in", 32'(lo_val[1]), 32'd7);
    for (int k = 2; k < 8; k++) chk("R2", "cleared register", 32'(lo_val[k]), 32'd0);
  endtask

  // No last flag: iteration wraps after slot 15.
  task automatic test_wrap;
    lin[0] = 0; lin[1] = 0; lin[2] = 0; lin[3] = 3; lin_n = 4;
    run_trace(3, 1'b0);
    chk("R4", "done_slot final slot", 32'(d_slot), 32'd15);
    chk("R4", "done_iters", 32'(d_iters), 32'd2);
    chk("R4", "r1 after wrap", 32'(lo_val[1]), 32'd2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done), 32'd0);
    chk("R1", "mem_valid after reset", 32'(mem_valid), 32'd0);
    chk("R1", "xout_valid after reset", 32'(xout_valid), 32'd0);

    // R3 trace 0: i++, acc+=step, addr++, store, guard i<N with last
    cfg_put(0, 0, cw(2, 0, 2, 2, 0, 1));
    cfg_put(0, 1, cw(1, 0, 1, 1, 4, 0));
    cfg_put(0, 2, cw(2, 0, 0, 0, 0, 1));
    cfg_put(0, 3, cw(3, 0, 0, 0, 1, 0));
    cfg_put(0, 4, cw(4, 1, 0, 2, 3, 0));
    // trace 1
    cfg_put(1, 0, cw(2, 0, 1, 1, 0, 1));
    cfg_put(1, 1, cw(3, 0, 0, 0, 1, 0));
    cfg_put(1, 2, cw(5, 0, 0, 1, 3, 0));
    cfg_put(1, 3, cw(2, 1, 0, 0, 0, 1));
    // trace 2: five stores
    for (int s = 0; s < 5; s++) cfg_put(2, s, cw(3, 0, 0, 0, 1, 0));
    cfg_put(2, 5, cw(0, 1, 0, 0, 0, 0));
    // trace 3: no last flag anywhere
    cfg_put(3, 0, cw(2, 0, 1, 1, 0, 1));
    for (int s = 1; s < 15; s++) cfg_put(3, s, cw(0, 0, 0, 0, 0, 0));
    cfg_put(3, 15, cw(4, 0, 0, 1, 3, 0));

    test_accumulate(1'b0);
    test_accumulate(1'b1);
    test_mid_guard();
    test_overflow();
    test_wrap();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule